// File: doc/BRIEF.md
# Bufferless Circuit-Setup Mesh Router

This block is one switching node of a two-dimensional on-chip mesh. The mesh uses hybrid packet and circuit switching. A single header word enters on one of five ports: four neighbour directions and one local attachment. The header names a destination coordinate. The router picks an output by resolving X before Y and reserves that output for the arriving input. It then passes the header on one cycle later. The router holds no payload storage of any kind. If the wanted output is taken, disabled, or lost in arbitration, the header is refused at once with a negative acknowledgement on the reverse link of its input.

Once the far end accepts the header, its positive acknowledgement travels back over the reverse links, one registered stage per router. The source may then stream payload at one word per cycle through the reserved circuit, with one cycle of delay per hop. The word flagged last frees the reservation in each router it crosses. A negative acknowledgement coming back from downstream also frees the reservation before it moves on toward the source. That is how a partially built path is dismantled.

Top module: `circ_router`

## Requirements
- R1: After synchronous reset every out_vld, in_ack and in_nack bit is low and every output is free.
- R2: A header word carries destination X in data bits [7:4] and Y in bits [3:0]. Port indices are 0 north, 1 east, 2 south, 3 west and 4 local. With the router at (MY_X, MY_Y): X greater goes east, X smaller goes west; with X equal, Y greater goes south, Y smaller goes north; both equal goes local.
- R3: A header that wins a free, enabled output appears on that output exactly one cycle later with out_hdr high and its data unchanged, and the output is reserved for that input.
- R4: A header aimed at an output that is already reserved produces in_nack on its own input one cycle later, and no word is emitted.
- R5: Headers that reach the same free output in the same cycle are resolved by round-robin. After reset input 0 has first turn, and afterwards the search starts just past the last winner. Every loser receives in_nack one cycle later.
- R6: out_nack arriving on a reserved output while its owner waits is returned as in_nack on the owner's input one cycle later, and the output becomes free.
- R7: out_ack arriving on a reserved output while its owner waits is returned as in_ack on the owner's input one cycle later, and the circuit is connected.
- R8: On a connected circuit each valid input word appears on the reserved output one cycle later, with out_hdr low and the same data and last flag, one word per cycle.
- R9: A word flagged last ends the circuit, so that the output accepts a new header from the cycle after the last word leaves.
- R10: A header routed to a port disabled in the PORT_EN mask is refused with in_nack one cycle later.
- R11: A valid non-header word on an input with no circuit, or on one still waiting for acknowledgement, is dropped and never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 5 | Word valid on each input link |
| in_hdr | input | 5 | Word is a routing header |
| in_last | input | 5 | Word is the final payload word |
| in_data | input | 80 | Five 16-bit input words, port p in bits [16p+15:16p] |
| in_ack | output | 5 | Positive acknowledgement toward each source |
| in_nack | output | 5 | Negative acknowledgement toward each source |
| out_vld | output | 5 | Word valid on each output link |
| out_hdr | output | 5 | Output word is a header |
| out_last | output | 5 | Output word is the final payload word |
| out_data | output | 80 | Five 16-bit output words |
| out_ack | input | 5 | Positive acknowledgement from each downstream node |
| out_nack | input | 5 | Negative acknowledgement from each downstream node |

## Verification
Routing is exercised with destinations on each side of the node and at the node itself, from several inputs. One case differs in both coordinates, which separates X-first ordering from Y-first ordering. Arbitration is tried with two headers arriving together twice in a row, which separates rotating priority from fixed priority. Full circuits with acknowledgement, a three-word stream and a last-word teardown are followed by a fresh header to the same output, which exposes any reservation left stuck. Stray words in the idle and waiting states, a refused header on a busy output, and a second router with one side disabled cover the refusal and drop paths.

// File: rtl/circ_pkg.sv
package circ_pkg;

    localparam int NPORT = 5;
    localparam int PIDX_W = 3;

    typedef enum logic [PIDX_W-1:0] {
        P_NORTH = 3'd0,
        P_EAST  = 3'd1,
        P_SOUTH = 3'd2,
        P_WEST  = 3'd3,
        P_LOCAL = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        IN_IDLE,
        IN_WAIT,
        IN_CONN
    } in_state_e;

    // Output word flags carried alongside the data word.
    typedef struct packed {
        logic vld;
        logic hdr;
        logic last;
    } word_flags_t;

    // Dimension-ordered selection: X is settled before Y.
    function automatic port_e route_xy(input int unsigned dx, input int unsigned dy,
                                       input int unsigned mx, input int unsigned my);
        if (dx > mx)      return P_EAST;
        else if (dx < mx) return P_WEST;
        else if (dy > my) return P_SOUTH;
        else if (dy < my) return P_NORTH;
        else              return P_LOCAL;
    endfunction

endpackage

// File: rtl/circ_rr_arb.sv
module circ_rr_arb #(
    parameter int NP = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt
);
    localparam int IW = $clog2(NP);

    logic [IW-1:0] last_q;
    logic [IW-1:0] win_idx;

    always_comb begin
        logic found;
        int   idx;
        gnt     = '0;
        found   = 1'b0;
        win_idx = '0;
        for (int k = 1; k <= NP; k++) begin
            idx = (int'(last_q) + k) % NP;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win_idx  = IW'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(NP - 1);
        end else if (|gnt) begin
            last_q <= win_idx;
        end
    end

endmodule

// File: rtl/circ_in_ctrl.sv
module circ_in_ctrl
    import circ_pkg::*;
#(
    parameter int NP   = NPORT,
    parameter int CW   = 4,
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          vld,
    input  logic          hdr,
    input  logic          last,
    input  logic [2*CW-1:0] coord,
    input  logic          granted,
    input  logic [NP-1:0] dn_ack,
    input  logic [NP-1:0] dn_nack,
    output logic          req,
    output port_e         dest,
    output logic          fwd,
    output logic          rel,
    output port_e         sel,
    output logic          ack_q,
    output logic          nack_q
);
    in_state_e st;
    logic      sel_ack;
    logic      sel_nack;

    assign dest     = route_xy(int'(coord[2*CW-1:CW]), int'(coord[CW-1:0]), MY_X, MY_Y);
    assign req      = en && (st == IN_IDLE) && vld && hdr;
    assign fwd      = (st == IN_CONN) && vld;
    assign sel_ack  = dn_ack[sel];
    assign sel_nack = dn_nack[sel];
    assign rel      = ((st == IN_WAIT) && sel_nack) || ((st == IN_CONN) && vld && last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= IN_IDLE;
            sel    <= P_LOCAL;
            ack_q  <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            ack_q  <= (st == IN_WAIT) && sel_ack && !sel_nack;
            nack_q <= (req && !granted) || ((st == IN_WAIT) && sel_nack);
            case (st)
                IN_IDLE: begin
                    if (req && granted) begin
                        st  <= IN_WAIT;
                        sel <= dest;
                    end
                end
                IN_WAIT: begin
                    if (sel_nack)     st <= IN_IDLE;
                    else if (sel_ack) st <= IN_CONN;
                end
                IN_CONN: begin
                    if (vld && last) st <= IN_IDLE;
                end
                default: st <= IN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/circ_out_slot.sv
module circ_out_slot
    import circ_pkg::*;
#(
    parameter int NP = NPORT,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    gnt,
    input  logic             rel,
    input  logic [NP-1:0]    fwd,
    input  logic [NP-1:0]    lastv,
    input  logic [NP*DW-1:0] din,
    output logic             busy,
    output word_flags_t      flags,
    output logic [DW-1:0]    data
);
    localparam int IW = $clog2(NP);

    logic [IW-1:0] owner;
    logic [IW-1:0] gidx;

    always_comb begin
        gidx = '0;
        for (int i = 0; i < NP; i++) begin
            if (gnt[i]) gidx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
            flags <= '0;
            data  <= '0;
        end else if (|gnt) begin
            busy  <= 1'b1;
            owner <= gidx;
            flags <= '{vld: 1'b1, hdr: 1'b1, last: 1'b0};
            data  <= din[int'(gidx)*DW +: DW];
        end else begin
            if (rel) busy <= 1'b0;
            if (busy && fwd[owner]) begin
                flags <= '{vld: 1'b1, hdr: 1'b0, last: lastv[owner]};
                data  <= din[int'(owner)*DW +: DW];
            end else begin
                flags <= '0;
                data  <= '0;
            end
        end
    end

endmodule

// File: rtl/circ_router.sv
module circ_router
    import circ_pkg::*;
#(
    parameter int              DW      = 16,
    parameter int              CW      = 4,
    parameter int              MY_X    = 1,
    parameter int              MY_Y    = 1,
    parameter logic [NPORT-1:0] PORT_EN = 5'b11111
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPORT-1:0]   in_vld,
    input  logic [NPORT-1:0]   in_hdr,
    input  logic [NPORT-1:0]   in_last,
    input  logic [NPORT*DW-1:0] in_data,
    output logic [NPORT-1:0]   in_ack,
    output logic [NPORT-1:0]   in_nack,
    output logic [NPORT-1:0]   out_vld,
    output logic [NPORT-1:0]   out_hdr,
    output logic [NPORT-1:0]   out_last,
    output logic [NPORT*DW-1:0] out_data,
    input  logic [NPORT-1:0]   out_ack,
    input  logic [NPORT-1:0]   out_nack
);
    localparam int NP = NPORT;

    logic [NP-1:0]          req_v;
    logic [NP-1:0]          fwd_v;
    logic [NP-1:0]          rel_v;
    logic [NP-1:0]          won;
    logic [NP-1:0]          rel_o;
    logic [NP-1:0]          out_busy;
    port_e                  req_port [NP];
    port_e                  sel_v    [NP];
    logic [NP-1:0][NP-1:0]  arb_req;
    logic [NP-1:0][NP-1:0]  arb_gnt;

    for (genvar i = 0; i < NP; i++) begin : g_in
        circ_in_ctrl #(
            .NP(NP), .CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)
        ) u_in (
            .clk     (clk),
            .rst     (rst),
            .en      (PORT_EN[i]),
            .vld     (in_vld[i]),
            .hdr     (in_hdr[i]),
            .last    (in_last[i]),
            .coord   (in_data[i*DW +: 2*CW]),
            .granted (won[i]),
            .dn_ack  (out_ack),
            .dn_nack (out_nack),
            .req     (req_v[i]),
            .dest    (req_port[i]),
            .fwd     (fwd_v[i]),
            .rel     (rel_v[i]),
            .sel     (sel_v[i]),
            .ack_q   (in_ack[i]),
            .nack_q  (in_nack[i])
        );
    end

    always_comb begin
        won   = '0;
        rel_o = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                arb_req[o][i] = req_v[i] && (req_port[i] == port_e'(o))
                                && PORT_EN[o] && !out_busy[o];
                if (arb_gnt[o][i]) won[i] = 1'b1;
                if (rel_v[i] && (sel_v[i] == port_e'(o))) rel_o[o] = 1'b1;
            end
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        word_flags_t fl;

        circ_rr_arb #(.NP(NP)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (arb_req[o]),
            .gnt (arb_gnt[o])
        );

        circ_out_slot #(.NP(NP), .DW(DW)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .gnt   (arb_gnt[o]),
            .rel   (rel_o[o]),
            .fwd   (fwd_v),
            .lastv (in_last),
            .din   (in_data),
            .busy  (out_busy[o]),
            .flags (fl),
            .data  (out_data[o*DW +: DW])
        );

        assign out_vld[o]  = fl.vld;
        assign out_hdr[o]  = fl.hdr;
        assign out_last[o] = fl.last;
    end

endmodule

// File: rtl/circ_router_chk.sv
module circ_router_chk #(
    parameter int NP = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [NP-1:0] in_vld,
    input logic [NP-1:0] in_hdr,
    input logic [NP-1:0] in_ack,
    input logic [NP-1:0] in_nack,
    input logic [NP-1:0] out_vld,
    input logic [NP-1:0] out_hdr,
    input logic [NP-1:0] out_last,
    input logic [NP-1:0] out_ack,
    input logic [NP-1:0] out_nack,
    input logic [NP-1:0] out_busy
);
    // R6 / R7: a source never sees both answers at once.
    p_single_answer_r7: assert property (@(posedge clk) disable iff (rst)
        (in_ack & in_nack) == '0);

    // R7: an acknowledgement toward a source follows one from downstream.
    p_ack_from_below_r7: assert property (@(posedge clk) disable iff (rst)
        (|in_ack) |-> $past(|out_ack));

    // R3: a forwarded header needs a header request the cycle before.
    p_hdr_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
        (|(out_vld & out_hdr)) |-> $past(|(in_vld & in_hdr)));

    for (genvar o = 0; o < NP; o++) begin : g_o
        // R3: a header on an output leaves it reserved.
        p_hdr_reserves_r3: assert property (@(posedge clk) disable iff (rst)
            (out_vld[o] && out_hdr[o]) |-> out_busy[o]);

        // R8: payload only leaves through an output that was reserved.
        p_payload_on_circuit_r8: assert property (@(posedge clk) disable iff (rst)
            (out_vld[o] && !out_hdr[o]) |-> $past(out_busy[o]));

        // R9 / R6: a reservation ends only by a last word or a refusal.
        p_free_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
            $fell(out_busy[o]) |-> ((out_vld[o] && out_last[o]) || $past(out_nack[o])));
    end

endmodule

bind circ_router circ_router_chk #(.NP(circ_pkg::NPORT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_hdr   (in_hdr),
    .in_ack   (in_ack),
    .in_nack  (in_nack),
    .out_vld  (out_vld),
    .out_hdr  (out_hdr),
    .out_last (out_last),
    .out_ack  (out_ack),
    .out_nack (out_nack),
    .out_busy (out_busy)
);

// File: tb/circ_router_tb_top.sv
module circ_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [NP-1:0]    in_vld, in_hdr, in_last, in_ack, in_nack;
    logic [NP-1:0]    out_vld, out_hdr, out_last, out_ack, out_nack;
    logic [NP*DW-1:0] in_data, out_data;

    logic [NP-1:0]    e_in_vld, e_in_hdr, e_in_last, e_in_ack, e_in_nack;
    logic [NP-1:0]    e_out_vld, e_out_hdr, e_out_last, e_out_ack, e_out_nack;
    logic [NP*DW-1:0] e_in_data, e_out_data;

    circ_router dut_i (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_hdr(in_hdr), .in_last(in_last), .in_data(in_data),
        .in_ack(in_ack), .in_nack(in_nack),
        .out_vld(out_vld), .out_hdr(out_hdr), .out_last(out_last), .out_data(out_data),
        .out_ack(out_ack), .out_nack(out_nack)
    );

    // West side disabled: an edge node.
    circ_router #(.PORT_EN(5'b10111)) dut_edge_i (
        .clk(clk), .rst(rst),
        .in_vld(e_in_vld), .in_hdr(e_in_hdr), .in_last(e_in_last), .in_data(e_in_data),
        .in_ack(e_in_ack), .in_nack(e_in_nack),
        .out_vld(e_out_vld), .out_hdr(e_out_hdr), .out_last(e_out_last), .out_data(e_out_data),
        .out_ack(e_out_ack), .out_nack(e_out_nack)
    );

    // {src[2:0], x[3:0], y[3:0], expected_port[2:0]}
    localparam logic [13:0] VEC [8] = '{
        {3'd4, 4'd2, 4'd1, 3'd1},
        {3'd4, 4'd0, 4'd1, 3'd3},
        {3'd4, 4'd1, 4'd2, 3'd2},
        {3'd4, 4'd1, 4'd0, 3'd0},
        {3'd0, 4'd1, 4'd1, 3'd4},
        {3'd1, 4'd3, 4'd3, 3'd1},
        {3'd2, 4'd0, 4'd3, 3'd3},
        {3'd3, 4'd2, 4'd0, 3'd1}
    };

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_all();
        in_vld = '0; in_hdr = '0; in_last = '0; in_data = '0;
        out_ack = '0; out_nack = '0;
        e_in_vld = '0; e_in_hdr = '0; e_in_last = '0; e_in_data = '0;
        e_out_ack = '0; e_out_nack = '0;
    endtask

    function automatic logic [15:0] hword(input int src, input int x, input int y);
        return {8'(8'hA0 + src), 4'(x), 4'(y)};
    endfunction

    task automatic put_hdr(input int p, input int x, input int y);
        in_vld[p] = 1'b1; in_hdr[p] = 1'b1;
        in_data[p*DW +: DW] = hword(p, x, y);
    endtask

    task automatic put_word(input int p, input logic [15:0] w, input logic lst);
        in_vld[p] = 1'b1; in_hdr[p] = 1'b0; in_last[p] = lst;
        in_data[p*DW +: DW] = w;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        idle_all();
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: quiet after reset
        chk("R1 out_vld", 32'(out_vld), 0);
        chk("R1 in_ack", 32'(in_ack), 0);
        chk("R1 in_nack", 32'(in_nack), 0);

        // R5: north and south both to local; north has first turn
        put_hdr(0, 1, 1); put_hdr(2, 1, 1);
        step(); idle_all();
        chk("R5 first winner data", 32'(out_data[4*DW +: DW]), 32'(hword(0, 1, 1)));
        chk("R5 loser nack", 32'(in_nack), 32'(5'b00100));
        out_nack[4] = 1'b1;
        step(); idle_all();
        chk("R6 nack to owner", 32'(in_nack), 32'(5'b00001));
        put_hdr(0, 1, 1); put_hdr(2, 1, 1);
        step(); idle_all();
        chk("R5 rotated winner data", 32'(out_data[4*DW +: DW]), 32'(hword(2, 1, 1)));
        chk("R5 rotated loser nack", 32'(in_nack), 32'(5'b00001));
        out_nack[4] = 1'b1;
        step(); idle_all();
        chk("R6 release", 32'(in_nack), 32'(5'b00100));

        // R2 / R3: routing vectors, each refused from below afterwards
        for (int v = 0; v < 8; v++) begin
            int s, x, y, e;
            s = int'(VEC[v][13:11]); x = int'(VEC[v][10:7]);
            y = int'(VEC[v][6:3]);   e = int'(VEC[v][2:0]);
            put_hdr(s, x, y);
            step(); idle_all();
            chk("R2 output select", 32'(out_vld), 32'(1 << e));
            chk("R3 header flag", 32'(out_hdr), 32'(1 << e));
            chk("R3 header data", 32'(out_data[e*DW +: DW]), 32'(hword(s, x, y)));
            chk("R3 no refusal", 32'(in_nack), 0);
            out_nack[e] = 1'b1;
            step(); idle_all();
            chk("R6 refusal returned", 32'(in_nack), 32'(1 << s));
        end

        // R7 / R8 / R9 / R4: full circuit local -> east
        put_hdr(4, 2, 1);
        step(); idle_all();
        chk("R3 header east", 32'(out_vld), 32'(5'b00010));
        out_ack[1] = 1'b1;
        step(); idle_all();
        chk("R7 ack to source", 32'(in_ack), 32'(5'b10000));
        put_hdr(3, 3, 1);
        step(); idle_all();
        chk("R4 busy refusal", 32'(in_nack), 32'(5'b01000));
        chk("R4 no word out", 32'(out_vld), 0);
        put_word(4, 16'h1234, 1'b0);
        step(); idle_all();
        chk("R8 word 1 valid", 32'(out_vld), 32'(5'b00010));
        chk("R8 word 1 not header", 32'(out_hdr), 0);
        chk("R8 word 1 data", 32'(out_data[DW +: DW]), 32'h1234);
        put_word(4, 16'h5678, 1'b0);
        step();
        chk("R8 word 2 data", 32'(out_data[DW +: DW]), 32'h5678);
        put_word(4, 16'h9ABC, 1'b1);
        step(); idle_all();
        chk("R8 word 3 data", 32'(out_data[DW +: DW]), 32'h9ABC);
        chk("R9 last flag", 32'(out_last), 32'(5'b00010));
        put_hdr(0, 3, 0);
        step(); idle_all();
        chk("R9 east free again", 32'(out_hdr), 32'(5'b00010));
        chk("R9 no refusal", 32'(in_nack), 0);
        out_nack[1] = 1'b1;
        step(); idle_all();

        // R11: stray word while idle, and payload while waiting
        put_word(0, 16'hDEAD, 1'b0);
        step(); idle_all();
        chk("R11 idle word dropped", 32'(out_vld), 0);
        put_hdr(4, 1, 2);
        step(); idle_all();
        chk("R3 header south", 32'(out_vld), 32'(5'b00100));
        put_word(4, 16'hBEEF, 1'b0);
        step(); idle_all();
        chk("R11 waiting word dropped", 32'(out_vld), 0);
        out_nack[2] = 1'b1;
        step(); idle_all();
        chk("R6 waiting path released", 32'(in_nack), 32'(5'b10000));

        // R10: edge node with west disabled
        e_in_vld[4] = 1'b1; e_in_hdr[4] = 1'b1; e_in_data[4*DW +: DW] = hword(4, 0, 1);
        step(); idle_all();
        chk("R10 disabled refusal", 32'(e_in_nack), 32'(5'b10000));
        chk("R10 nothing emitted", 32'(e_out_vld), 0);
        e_in_vld[4] = 1'b1; e_in_hdr[4] = 1'b1; e_in_data[4*DW +: DW] = hword(4, 2, 1);
        step(); idle_all();
        chk("R10 enabled side works", 32'(e_out_vld), 32'(5'b00010));

        done = 1'b1;
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

endmodule